// File: doc/BRIEF.md
# Sequential-Prefetch Read Cache Controller

This block connects a processor's single-word read/write port to a slow, word-addressed backing memory. It holds a small direct-mapped store of words, each with a tag and a valid bit. A read whose address is held is answered from the store in one cycle. A read that is not held stalls the processor just long enough to fetch that one word. The controller then drops the stall and, while the processor carries on, reads a fixed run of the words that follow the missed address into the store.

Writes always go through to memory. If the written address is held, its copy is refreshed. A write that misses does not allocate an entry. The backing memory uses a single request/acknowledge handshake with variable latency, and only one transaction is outstanding at a time. Processor demand therefore takes priority over the background run. A new read miss abandons the run. A read of the word the run is fetching joins that fetch instead of repeating it. A write to that word keeps the fetched data out of the store.

Top module: `seqpf_cache`

## Requirements
- R1: After reset every store entry is invalid, `cpu_busy`, `mem_req` and `cpu_rvalid` are low, and the first read of any address reaches memory.
- R2: A read accepted (`cpu_req` high while `cpu_busy` low) whose address is held raises `cpu_rvalid` with the stored word in the next cycle, issues no memory read for it and leaves `cpu_busy` low.
- R3: A read miss raises `cpu_busy` the cycle after acceptance. The first memory read issued for it is the requested address. `cpu_rvalid` and the memory word appear the cycle after `mem_ack`, when `cpu_busy` falls.
- R4: After a miss at address A, the controller reads A+1 through A+16 (modulo 2^ADDR_W) in ascending order and installs them, so later reads of those addresses hit. A+17 is not fetched by that run.
- R5: While the run is active `cpu_busy` stays low, and hits are answered in one cycle while the run continues.
- R6: A read miss accepted during a run stops the run. The memory transaction already in flight completes, the next memory read is the new demand address, and a new run starts from that address.
- R7: A read of the address whose prefetch is in flight waits for that fetch and returns its data, with no second memory read of that address.
- R8: A write (`cpu_we`=1) issues one memory write with `mem_we`=1, the address and the data, and holds `cpu_busy` until it is acknowledged. It updates a held copy. A write that misses does not allocate: a later read of that address misses.
- R9: A write to the address whose prefetch is in flight prevents that prefetched word from being installed, so a later read of that address is served from memory with the written value.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | Controller cannot take a request |
| cpu_rvalid | output | 1 | One-cycle pulse with read data |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the pending transaction this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The bench aims at the edges of the prefetch run.
- Address A+16 must hit and A+17 must miss. A run one word short or long shows up as an unexpected or missing memory read.
- A demand miss is issued while a prefetch is in flight. A design that keeps prefetching would log old-run addresses ahead of the demand address.
- A read joins an in-flight prefetch. Issuing a duplicate would show two memory reads of that word.
- A write to the in-flight prefetch word is followed by a read of it. Installing the stale word would return the old memory value to the scoreboard.
- A write miss is followed by a read of that address. A write-allocate design would hit instead of reading memory.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = 5;
    localparam int PF_RUN  = 16;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W;
    localparam int CNT_W   = $clog2(PF_RUN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {ST_READY, ST_MISS, ST_WR, ST_JOIN} state_e;
    typedef enum logic [1:0] {MK_PF, MK_RD, MK_WR} mkind_e;

    typedef struct packed {
        logic   act;
        mkind_e kind;
        addr_t  addr;
        data_t  wdata;
    } mem_txn_t;

    function automatic idx_t idx_of(addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/seqpf_store.sv
module seqpf_store
    import seqpf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t lk_addr,
    output logic  lk_hit,
    output data_t lk_data,
    input  logic  fill_en,
    input  addr_t fill_addr,
    input  data_t fill_data,
    input  logic  upd_en,
    input  addr_t upd_addr,
    input  data_t upd_data
);
    logic [ENTRIES-1:0] valid;
    tag_t  tag_q  [ENTRIES];
    data_t data_q [ENTRIES];

    logic upd_hit;
    assign upd_hit = upd_en && valid[idx_of(upd_addr)] && (tag_q[idx_of(upd_addr)] == tag_of(upd_addr));
    assign lk_hit  = valid[idx_of(lk_addr)] && (tag_q[idx_of(lk_addr)] == tag_of(lk_addr));
    assign lk_data = data_q[idx_of(lk_addr)];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic upd_here, fill_here;
        assign upd_here  = upd_hit && (idx_of(upd_addr) == idx_t'(e));
        assign fill_here = fill_en && (idx_of(fill_addr) == idx_t'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[e] <= 1'b0;
            end else if (upd_here) begin
                data_q[e] <= upd_data;
            end else if (fill_here) begin
                valid[e]  <= 1'b1;
                tag_q[e]  <= tag_of(fill_addr);
                data_q[e] <= fill_data;
            end
        end
    end

    // R1: store is empty in the first cycle after reset
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid == '0));
endmodule

// File: rtl/seqpf_runner.sv
module seqpf_runner
    import seqpf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  addr_t start_addr,
    input  logic  abort,
    input  logic  launch,
    output logic  want,
    output addr_t next_addr
);
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left      <= '0;
            next_addr <= '0;
        end else if (abort) begin
            left <= '0;
        end else if (start) begin
            left      <= CNT_W'(PF_RUN);
            next_addr <= start_addr + addr_t'(1);
        end else if (launch) begin
            left      <= left - CNT_W'(1);
            next_addr <= next_addr + addr_t'(1);
        end
    end

    assign want = (left != '0);

    // R6: an abandoned run issues nothing further
    a_r6_abort_stops: assert property (@(posedge clk) disable iff (rst)
        abort |=> !want);
    // R4: the controller only launches words the run still owes
    a_r4_launch_owed: assert property (@(posedge clk) disable iff (rst)
        launch |-> want);
endmodule

// File: rtl/seqpf_cache.sv
module seqpf_cache
    import seqpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    state_e   st;
    mem_txn_t mt;
    logic     pend, pf_stale;
    addr_t    req_addr;
    data_t    req_wdata;

    logic  lk_hit, pf_want;
    data_t lk_data;
    addr_t pf_next;

    logic accept, acc_rd, acc_wr, ack, mem_free;
    logic pf_match, miss, wr_collide, fill_en;
    logic launch_dem, launch_pf, pf_start;

    assign accept     = cpu_req && (st == ST_READY);
    assign acc_rd     = accept && !cpu_we;
    assign acc_wr     = accept && cpu_we;
    assign ack        = mt.act && mem_ack;
    assign mem_free   = !mt.act || mem_ack;
    assign pf_match   = mt.act && (mt.kind == MK_PF) && !pf_stale && (mt.addr == cpu_addr);
    assign miss       = acc_rd && !lk_hit && !pf_match;
    assign wr_collide = acc_wr && mt.act && (mt.kind == MK_PF) && (mt.addr == cpu_addr);
    assign fill_en    = ack && ((mt.kind == MK_RD) ||
                                ((mt.kind == MK_PF) && !pf_stale && !wr_collide));
    assign launch_dem = ((st == ST_MISS) || (st == ST_WR)) && pend && mem_free;
    assign launch_pf  = (st == ST_READY) && !accept && pf_want && mem_free;
    assign pf_start   = ack && (mt.kind == MK_RD);

    seqpf_store u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_addr   (cpu_addr),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .fill_en   (fill_en),
        .fill_addr (mt.addr),
        .fill_data (mem_rdata),
        .upd_en    (acc_wr),
        .upd_addr  (cpu_addr),
        .upd_data  (cpu_wdata)
    );

    seqpf_runner u_runner (
        .clk        (clk),
        .rst        (rst),
        .start      (pf_start),
        .start_addr (mt.addr),
        .abort      (miss),
        .launch     (launch_pf),
        .want       (pf_want),
        .next_addr  (pf_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_READY;
            mt         <= '0;
            pend       <= 1'b0;
            pf_stale   <= 1'b0;
            req_addr   <= '0;
            req_wdata  <= '0;
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= 1'b0;
            if (ack) mt.act <= 1'b0;
            if (launch_dem) begin
                mt.act   <= 1'b1;
                mt.kind  <= (st == ST_MISS) ? MK_RD : MK_WR;
                mt.addr  <= req_addr;
                mt.wdata <= req_wdata;
                pend     <= 1'b0;
            end else if (launch_pf) begin
                mt.act   <= 1'b1;
                mt.kind  <= MK_PF;
                mt.addr  <= pf_next;
                mt.wdata <= '0;
                pf_stale <= 1'b0;
            end
            if (miss || wr_collide) pf_stale <= 1'b1;

            case (st)
                ST_READY: begin
                    if (acc_rd) begin
                        if (lk_hit) begin
                            cpu_rvalid <= 1'b1;
                            cpu_rdata  <= lk_data;
                        end else if (pf_match && mem_ack) begin
                            cpu_rvalid <= 1'b1;
                            cpu_rdata  <= mem_rdata;
                        end else if (pf_match) begin
                            st <= ST_JOIN;
                        end else begin
                            st       <= ST_MISS;
                            pend     <= 1'b1;
                            req_addr <= cpu_addr;
                        end
                    end else if (acc_wr) begin
                        st        <= ST_WR;
                        pend      <= 1'b1;
                        req_addr  <= cpu_addr;
                        req_wdata <= cpu_wdata;
                    end
                end
                ST_MISS: if (ack && (mt.kind == MK_RD)) begin
                    cpu_rvalid <= 1'b1;
                    cpu_rdata  <= mem_rdata;
                    st         <= ST_READY;
                end
                ST_WR: if (ack && (mt.kind == MK_WR)) st <= ST_READY;
                ST_JOIN: if (ack) begin
                    cpu_rvalid <= 1'b1;
                    cpu_rdata  <= mem_rdata;
                    st         <= ST_READY;
                end
                default: st <= ST_READY;
            endcase
        end
    end

    assign cpu_busy  = (st != ST_READY);
    assign mem_req   = mt.act;
    assign mem_we    = (mt.kind == MK_WR);
    assign mem_addr  = mt.addr;
    assign mem_wdata = mt.wdata;

    // R2: a held word is answered in the next cycle without stalling
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && lk_hit) |=> (cpu_rvalid && !cpu_busy));
    // R3: a demand miss stalls the processor and gives no data yet
    a_r3_miss_stalls: assert property (@(posedge clk) disable iff (rst)
        miss |=> (cpu_busy && !cpu_rvalid));
    // R7: while joined, a memory read is outstanding
    a_r7_join_outstanding: assert property (@(posedge clk) disable iff (rst)
        (st == ST_JOIN) |-> (mem_req && !mem_we));
    // R10: memory request fields hold until acknowledged
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/seqpf_cache_tb_top.sv
module seqpf_cache_tb_top;
    import seqpf_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  cpu_req = 1'b0, cpu_we = 1'b0;
    addr_t cpu_addr = '0;
    data_t cpu_wdata = '0;
    logic  cpu_busy, cpu_rvalid, mem_req, mem_we;
    data_t cpu_rdata, mem_wdata;
    addr_t mem_addr;
    logic  mem_ack = 1'b0;
    data_t mem_rdata = '0;

    always #5 clk = ~clk;

    seqpf_cache dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic data_t init_val(addr_t a);
        return data_t'(a) * 16'h03B1 ^ 16'hA5C3;
    endfunction

    // memory model and reference copy
    data_t wmem [addr_t];
    data_t rmem [addr_t];
    int    lat = 2;
    int    cnt = 0;
    addr_t rd_log [0:511];
    int    rd_n = 0;
    addr_t wr_last_addr = '0;
    data_t wr_last_data = '0;
    int    hold_viol = 0;
    bit    waiting = 0;
    addr_t held_addr = '0;

    function automatic data_t mval(addr_t a);
        return wmem.exists(a) ? wmem[a] : init_val(a);
    endfunction
    function automatic data_t rval(addr_t a);
        return rmem.exists(a) ? rmem[a] : init_val(a);
    endfunction
    function automatic int reads_of(addr_t a);
        int c = 0;
        for (int i = 0; i < rd_n; i++) if (rd_log[i] == a) c++;
        return c;
    endfunction

    always @(negedge clk) begin
        if (waiting && (!mem_req || mem_addr != held_addr)) hold_viol++;
        waiting = 0;
        if (mem_ack) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            cnt++;
            if (cnt >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    wmem[mem_addr] = mem_wdata;
                    wr_last_addr = mem_addr;
                    wr_last_data = mem_wdata;
                end else begin
                    mem_rdata = mval(mem_addr);
                    if (rd_n < 512) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end else begin
                waiting = 1;
                held_addr = mem_addr;
            end
        end
    end

    // scoreboard
    data_t exp_q [$];
    string tag_q [$];

    always @(negedge clk) begin
        if (cpu_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected response", int'(cpu_rdata), 0);
            end else begin
                data_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cpu_rdata == e, t, int'(cpu_rdata), int'(e));
            end
        end
    end

    task automatic cpu_read(input addr_t a, input string tag);
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        exp_q.push_back(rval(a));
        tag_q.push_back(tag);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic cpu_write(input addr_t a, input data_t d);
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        rmem[a] = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_rsp();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 8) begin
            @(negedge clk);
            if (mem_req || cpu_busy) q = 0; else q++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base, k;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(cpu_busy == 0, "R1 busy after reset", int'(cpu_busy), 0);
        chk(mem_req == 0, "R1 mem_req after reset", int'(mem_req), 0);
        chk(cpu_rvalid == 0, "R1 rvalid after reset", int'(cpu_rvalid), 0);

        // R3 demand miss
        lat = 3;
        cpu_read(12'h100, "R3 miss data");
        chk(cpu_busy == 1, "R3 busy during miss", int'(cpu_busy), 1);
        wait_rsp();
        chk(rd_n >= 1 && rd_log[0] == 12'h100, "R3 first memory read", int'(rd_log[0]), 'h100);
        chk(reads_of(12'h100) == 1, "R1 empty store reaches memory", reads_of(12'h100), 1);

        // R4 run contents and length
        wait_idle();
        chk(rd_n == 17, "R4 run length", rd_n, 17);
        k = 0;
        for (int i = 1; i <= 16; i++) if (rd_log[i] != addr_t'(12'h100 + i)) k++;
        chk(k == 0, "R4 run order", k, 0);
        base = rd_n;
        cpu_read(12'h105, "R4 prefetched word");
        chk(cpu_rvalid == 1, "R2 hit next cycle", int'(cpu_rvalid), 1);
        cpu_read(12'h110, "R4 last word of run");
        chk(cpu_rvalid == 1, "R4 A+16 hits", int'(cpu_rvalid), 1);
        chk(rd_n == base, "R2 hit issues no memory read", rd_n, base);
        cpu_read(12'h111, "R4 A+17 data");
        wait_rsp();
        chk(rd_log[base] == 12'h111, "R4 A+17 misses", int'(rd_log[base]), 'h111);

        // R5 background run with hits
        lat = 4;
        cpu_read(12'h110, "R5 hit during run");
        chk(cpu_rvalid == 1, "R5 hit answered during run", int'(cpu_rvalid), 1);
        chk(mem_req == 1, "R5 run still active", int'(mem_req), 1);
        wait_idle();
        chk(rd_n == base + 17, "R5 run completes", rd_n, base + 17);
        k = 0;
        for (int i = 1; i <= 16; i++) if (rd_log[base + i] != addr_t'(12'h111 + i)) k++;
        chk(k == 0, "R5 run order with hits", k, 0);

        // R6 abandon
        base = rd_n;
        cpu_read(12'h300, "R6 first miss");
        wait_rsp();
        cpu_read(12'h500, "R6 second miss data");
        wait_rsp();
        wait_idle();
        k = 1;
        while (base + k < rd_n && rd_log[base + k] == addr_t'(12'h300 + k)) k++;
        chk(base + k < rd_n && rd_log[base + k] == 12'h500, "R6 demand after abandon",
            int'(rd_log[base + k]), 'h500);
        chk(k < 4, "R6 old run cut short", k, 1);
        chk(base + k + 1 < rd_n && rd_log[base + k + 1] == 12'h501, "R6 new run",
            int'(rd_log[base + k + 1]), 'h501);
        chk(reads_of(12'h30C) == 0, "R6 no late old-run read", reads_of(12'h30C), 0);

        // R7 join in-flight prefetch
        cpu_read(12'h700, "R7 miss");
        wait_rsp();
        cpu_read(12'h701, "R7 joined data");
        wait_rsp();
        chk(reads_of(12'h701) == 1, "R7 single read", reads_of(12'h701), 1);
        wait_idle();

        // R8 write-through
        cpu_write(12'h705, 16'hBEEF);
        chk(cpu_busy == 1, "R8 busy during write", int'(cpu_busy), 1);
        wait_idle();
        chk(wr_last_addr == 12'h705 && wr_last_data == 16'hBEEF, "R8 memory write",
            int'(wr_last_data), 'hBEEF);
        base = rd_n;
        cpu_read(12'h705, "R8 updated copy");
        chk(cpu_rvalid == 1 && rd_n == base, "R8 copy still held", rd_n, base);
        cpu_write(12'h900, 16'h1234);
        cpu_read(12'h900, "R8 write miss data");
        wait_rsp();
        chk(reads_of(12'h900) == 1, "R8 no allocate", reads_of(12'h900), 1);
        wait_idle();

        // R9 stale prefetch
        cpu_read(12'hA00, "R9 miss");
        wait_rsp();
        cpu_write(12'hA01, 16'h7777);
        cpu_read(12'hA01, "R9 written value");
        wait_rsp();
        chk(reads_of(12'hA01) == 2, "R9 stale word not installed", reads_of(12'hA01), 2);
        wait_idle();

        chk(hold_viol == 0, "R10 request held", hold_viol, 0);
        chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule